// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves blocks of words between I/O devices and memory without the data passing through it. Each of four channels holds a start address, a word count, a direction and an enable. Software loads all four fields of one channel with a single write. A device asks for service by raising its request line. The controller then asks the processor for the bus with a hold request and waits for hold acknowledge. Once the bus is granted it acknowledges the device and drives the address and one pair of strobes, one word per clock. Memory and the device exchange the data directly on the bus.

After each word the channel's address steps up by one and its count steps down by one. When the final word has moved, the controller releases the bus, pulses a completion interrupt that carries the channel number, and disables that channel. Only one channel owns the bus at a time. A new channel is chosen only while the controller is idle, and the lowest-numbered requester wins.

Top module: `dma_flyby`

## Requirements
- R1: A cycle with `cfg_we_i` high loads the address, count, direction and enable of channel `cfg_ch_i` from the `cfg_*` inputs. A write whose count is 0 leaves that channel disabled, so its requests then start nothing.
- R2: After reset, `hold_req_o`, all strobes, `dack_o` and `irq_o` are low. `hold_req_o` rises the cycle after an enabled channel's `dreq_i` bit is sampled high while idle. No strobe, address or `dack_o` is driven in any cycle where `hold_ack_i` is low.
- R3: `hold_req_o` stays high from the request until the last word has moved and falls in the cycle that follows the last word.
- R4: While a word moves, `dack_o` is one-hot with bit n set for serviced channel n. At all other times `dack_o` is zero.
- R5: Direction 0 (memory to device) asserts `mem_rd_o` and `io_wr_o`. Direction 1 (device to memory) asserts `io_rd_o` and `mem_wr_o`. Memory read and memory write are never asserted together.
- R6: Exactly one word moves in each cycle where the bus is granted, at the channel's current address. The address then increments, wrapping from 0xFFFF to 0x0000, and the count decrements. A cycle with `hold_ack_i` low moves no word and pauses the transfer without losing its place.
- R7: In the cycle after the last word, `irq_o` is high for exactly one cycle and `irq_ch_o` holds the finished channel's number. That channel's enable is cleared, so its further requests are ignored until it is rewritten.
- R8: When several enabled channels request at once, the lowest-numbered one is serviced first. A channel is picked only while no transfer is in progress, and the others follow in turn.
- R9: A request on a channel whose enable is clear never raises `hold_req_o`.
- R10: A write to the channel currently being serviced is ignored. A write to any other channel takes effect during a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Channel program strobe |
| cfg_ch_i | input | 2 | Channel selected by the write |
| cfg_addr_i | input | 16 | Start address |
| cfg_cnt_i | input | 16 | Word count |
| cfg_dir_i | input | 1 | 0: memory to device, 1: device to memory |
| cfg_en_i | input | 1 | Enable for the channel |
| dreq_i | input | 4 | Device request lines, one per channel |
| hold_req_o | output | 1 | Bus request to the processor |
| hold_ack_i | input | 1 | Bus grant from the processor |
| dack_o | output | 4 | Device acknowledge, one per channel |
| addr_o | output | 16 | Memory address of the current word |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |
| irq_o | output | 1 | Completion pulse |
| irq_ch_o | output | 2 | Channel that completed |

## Verification
The main transfer path is tried with four patterns.

- A lone channel in each direction shows that the strobe pairs are chosen correctly.
- A block that starts at 0xFFFE shows that the address wraps.
- Two channels requesting together show that priority and back-to-back handover work.
- A grant withdrawn in mid-block shows that the transfer pauses and then resumes at the right address.

Further cases check that the design rejects input it should not act on: a zero-count enable, a request on a channel that has completed, and a reprogram of the busy channel. The reprogram case is paired with a write to an idle channel, which must take effect.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_MOVE = 2'd2
  } dma_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic          wr_dir_i,
  input  logic          wr_en_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      dir_o  <= 1'b0;
      en_o   <= 1'b0;
    end else if (wr_i) begin
      addr_o <= wr_addr_i;
      cnt_o  <= wr_cnt_i;
      dir_o  <= wr_dir_i;
      en_o   <= wr_en_i && (wr_cnt_i != '0);
    end else if (step_i) begin
      addr_o <= addr_o + AW'(1);
      cnt_o  <= cnt_o - CW'(1);
      if (cnt_o == CW'(1)) en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    vld_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CHW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_vld_i,
  input  logic [CHW-1:0] req_ch_i,
  input  logic           hold_ack_i,
  input  logic           last_i,
  output logic           hold_req_o,
  output logic           move_o,
  output logic           busy_o,
  output logic [CHW-1:0] act_ch_o,
  output logic           irq_o
);
  dma_state_e st_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      act_ch_o <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_vld_i) begin
          act_ch_o <= req_ch_i;
          st_q     <= ST_HOLD;
        end
        ST_HOLD: if (hold_ack_i) st_q <= ST_MOVE;
        ST_MOVE: if (hold_ack_i && last_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign hold_req_o = busy_o;
  assign move_o     = (st_q == ST_MOVE) && hold_ack_i;
  assign irq_o      = done_q;
endmodule

// File: rtl/dma_flyby.sv
module dma_flyby #(
  parameter int NCH  = 4,
  parameter int AW   = 16,
  parameter int CW   = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [AW-1:0]  cfg_addr_i,
  input  logic [CW-1:0]  cfg_cnt_i,
  input  logic           cfg_dir_i,
  input  logic           cfg_en_i,
  input  logic [NCH-1:0] dreq_i,
  output logic           hold_req_o,
  input  logic           hold_ack_i,
  output logic [NCH-1:0] dack_o,
  output logic [AW-1:0]  addr_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           io_wr_o,
  output logic           irq_o,
  output logic [CHW-1:0] irq_ch_o
);
  logic [NCH-1:0] en_v, dir_v, wr_v, step_v, last_v;
  logic [AW-1:0]  addr_v [NCH];
  logic [CW-1:0]  cnt_v  [NCH];
  logic           busy, move, arb_vld, cur_dir;
  logic [CHW-1:0] act_ch, arb_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // the busy channel is locked against reprogramming
    assign wr_v[g]   = cfg_we_i && (cfg_ch_i == CHW'(g)) && !(busy && act_ch == CHW'(g));
    assign step_v[g] = move && (act_ch == CHW'(g));
    assign last_v[g] = (cnt_v[g] == CW'(1));

    dma_chan_regs #(.AW(AW), .CW(CW)) i_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_v[g]),
      .wr_addr_i (cfg_addr_i),
      .wr_cnt_i  (cfg_cnt_i),
      .wr_dir_i  (cfg_dir_i),
      .wr_en_i   (cfg_en_i),
      .step_i    (step_v[g]),
      .addr_o    (addr_v[g]),
      .cnt_o     (cnt_v[g]),
      .dir_o     (dir_v[g]),
      .en_o      (en_v[g])
    );
  end

  dma_prio_arb #(.N(NCH)) i_arb (
    .req_i (dreq_i & en_v & {NCH{!busy}}),
    .vld_o (arb_vld),
    .idx_o (arb_idx)
  );

  dma_seq #(.CHW(CHW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vld_i  (arb_vld),
    .req_ch_i   (arb_idx),
    .hold_ack_i (hold_ack_i),
    .last_i     (last_v[act_ch]),
    .hold_req_o (hold_req_o),
    .move_o     (move),
    .busy_o     (busy),
    .act_ch_o   (act_ch),
    .irq_o      (irq_o)
  );

  assign cur_dir  = dir_v[act_ch];
  assign dack_o   = move ? (NCH'(1) << act_ch) : '0;
  assign addr_o   = move ? addr_v[act_ch] : '0;
  assign mem_rd_o = move && !cur_dir;
  assign io_wr_o  = move && !cur_dir;
  assign io_rd_o  = move && cur_dir;
  assign mem_wr_o = move && cur_dir;
  assign irq_ch_o = act_ch;
endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hold_req_o,
  input logic           hold_ack_i,
  input logic [NCH-1:0] dack_o,
  input logic [AW-1:0]  addr_o,
  input logic           mem_rd_o,
  input logic           mem_wr_o,
  input logic           io_rd_o,
  input logic           io_wr_o,
  input logic           irq_o
);
  logic mv, any_bus;
  assign mv      = mem_rd_o | mem_wr_o;
  assign any_bus = mv | io_rd_o | io_wr_o | (|dack_o);

  p_bus_needs_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_bus |-> (hold_ack_i && hold_req_o));

  p_dack_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o) && ((|dack_o) == mv));

  p_strobe_pairs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv |-> ((mem_rd_o ^ mem_wr_o) && (mem_rd_o == io_wr_o) && (mem_wr_o == io_rd_o)));

  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv ##1 mv) |-> (addr_o == $past(addr_o) + AW'(1)));

  p_release_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_o) |-> irq_o);

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !hold_req_o);
endmodule

bind dma_flyby dma_flyby_chk #(.NCH(NCH), .AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_req_o (hold_req_o),
  .hold_ack_i (hold_ack_i),
  .dack_o     (dack_o),
  .addr_o     (addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .io_rd_o    (io_rd_o),
  .io_wr_o    (io_wr_o),
  .irq_o      (irq_o)
);

// File: tb/test_dma_flyby.sv
module test_dma_flyby;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_ch_i = '0;
  logic [15:0] cfg_addr_i = '0;
  logic [15:0] cfg_cnt_i = '0;
  logic        cfg_dir_i = 1'b0;
  logic        cfg_en_i = 1'b0;
  logic [3:0]  dreq_i = '0;
  logic        hold_req_o, hold_ack_i;
  logic [3:0]  dack_o;
  logic [15:0] addr_o;
  logic        mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, irq_o;
  logic [1:0]  irq_ch_o;

  always #2 clk_i = ~clk_i;

  dma_flyby i_dma_flyby (.*);

  typedef struct packed {
    logic [15:0] a;
    logic [3:0]  dk;
    logic [3:0]  st;
  } item_t;

  item_t      exp_q[$];
  logic [1:0] irq_q[$];
  int vectors = 0;
  int fails = 0;
  int words_seen = 0;
  logic granted = 1'b0;
  logic drop = 1'b0;
  assign hold_ack_i = granted & ~drop;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // processor model: grants the bus two cycles after the request
  initial begin
    int dly = 0;
    forever begin
      @(posedge clk_i); #1;
      if (!hold_req_o) begin
        granted = 1'b0;
        dly = 0;
      end else if (!granted) begin
        if (dly == 2) granted = 1'b1;
        else dly++;
      end
    end
  end

  // monitor: pop expected words and completions as they appear
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && (mem_rd_o | mem_wr_o | io_rd_o | io_wr_o | (|dack_o))) begin
        words_seen++;
        chk(hold_ack_i, "R2", "bus driven without grant", {31'd0, hold_ack_i}, 32'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected word at addr", {16'd0, addr_o}, 32'd0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(addr_o == e.a, "R6", "word address", {16'd0, addr_o}, {16'd0, e.a});
          chk(dack_o == e.dk, "R4", "device acknowledge", {28'd0, dack_o}, {28'd0, e.dk});
          chk({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o} == e.st, "R5", "strobes",
              {28'd0, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}, {28'd0, e.st});
        end
      end
      if (rst_ni && irq_o) begin
        chk(!hold_req_o, "R3", "hold still high at completion", {31'd0, hold_req_o}, 32'd0);
        chk(exp_q.size() == 0 || irq_q.size() > 1, "R3", "words left at completion",
            exp_q.size(), 32'd0);
        if (irq_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected completion of channel", {30'd0, irq_ch_o}, 32'd0);
        end else begin
          logic [1:0] c;
          c = irq_q.pop_front();
          chk(irq_ch_o == c, "R7", "completion channel", {30'd0, irq_ch_o}, {30'd0, c});
        end
      end
    end
  end

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] n,
                      input logic d, input logic en);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_addr_i = a;
    cfg_cnt_i = n; cfg_dir_i = d; cfg_en_i = en;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  // driver: push the words a programmed block must produce
  task automatic expect_blk(input int ch, input logic [15:0] a, input int n, input logic d);
    for (int i = 0; i < n; i++) begin
      item_t e;
      e.a  = a + 16'(i);
      e.dk = 4'(1 << ch);
      e.st = d ? 4'b0110 : 4'b1001;
      exp_q.push_back(e);
    end
    irq_q.push_back(2'(ch));
  endtask

  task automatic wait_drained(input string rq);
    int n = 0;
    while ((exp_q.size() != 0 || irq_q.size() != 0 || hold_req_o) && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk(n < 2000, rq, "block did not finish, words left", exp_q.size(), 32'd0);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic expect_quiet(input string rq, input int cyc);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (hold_req_o) seen = 1'b1;
    end
    chk(!seen, rq, "hold request raised", {31'd0, seen}, 32'd0);
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!hold_req_o && !irq_o && dack_o == 0 && !(mem_rd_o | mem_wr_o | io_rd_o | io_wr_o),
        "R2", "reset outputs", {hold_req_o, irq_o, dack_o}, 32'd0);

    // R5 dir 0 on channel 2
    prog(2, 16'h1000, 16'd3, 1'b0, 1'b1);
    expect_blk(2, 16'h1000, 3, 1'b0);
    @(posedge clk_i); #1 dreq_i = 4'b0100;
    @(negedge clk_i); @(negedge clk_i);
    chk(hold_req_o, "R2", "hold request after dreq", {31'd0, hold_req_o}, 32'd1);
    wait_drained("R3");
    #1 dreq_i = '0;

    // R6 dir 1 with address wrap on channel 1
    prog(1, 16'hFFFE, 16'd3, 1'b1, 1'b1);
    expect_blk(1, 16'hFFFE, 3, 1'b1);
    @(posedge clk_i); #1 dreq_i = 4'b0010;
    wait_drained("R6");
    #1 dreq_i = '0;

    // R8 simultaneous requests, channel 0 before channel 3
    prog(3, 16'h0300, 16'd2, 1'b1, 1'b1);
    prog(0, 16'h0A00, 16'd4, 1'b0, 1'b1);
    expect_blk(0, 16'h0A00, 4, 1'b0);
    expect_blk(3, 16'h0300, 2, 1'b1);
    @(posedge clk_i); #1 dreq_i = 4'b1001;
    wait_drained("R8");

    // R7 / R9: completed channels are disabled, requests still high
    expect_quiet("R9", 12);
    #1 dreq_i = '0;

    // R1 zero count does not enable
    prog(0, 16'h0500, 16'd0, 1'b0, 1'b1);
    @(posedge clk_i); #1 dreq_i = 4'b0001;
    expect_quiet("R1", 12);
    #1 dreq_i = '0;

    // R6 grant withdrawn mid-block
    prog(1, 16'h0040, 16'd5, 1'b0, 1'b1);
    expect_blk(1, 16'h0040, 5, 1'b0);
    begin
      int base = words_seen;
      @(posedge clk_i); #1 dreq_i = 4'b0010;
      while (words_seen < base + 2) @(negedge clk_i);
    end
    @(posedge clk_i); #1 drop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(!(mem_rd_o | mem_wr_o | io_rd_o | io_wr_o) && hold_req_o, "R6",
          "activity during withdrawn grant", {mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}, 32'd0);
    end
    @(posedge clk_i); #1 drop = 1'b0;
    wait_drained("R6");
    #1 dreq_i = '0;

    // R10 reprogram busy channel ignored, other channel accepted
    prog(2, 16'h2000, 16'd4, 1'b1, 1'b1);
    expect_blk(2, 16'h2000, 4, 1'b1);
    begin
      int base = words_seen;
      @(posedge clk_i); #1 dreq_i = 4'b0100;
      while (words_seen < base + 1) @(negedge clk_i);
    end
    prog(2, 16'h5000, 16'd9, 1'b0, 1'b1);
    prog(1, 16'h3000, 16'd2, 1'b1, 1'b1);
    wait_drained("R10");
    expect_quiet("R7", 6);
    expect_blk(1, 16'h3000, 2, 1'b1);
    @(posedge clk_i); #1 dreq_i = 4'b0110;
    wait_drained("R10");
    #1 dreq_i = '0;
    chk(exp_q.size() == 0 && irq_q.size() == 0, "R6", "scoreboard residue",
        exp_q.size() + irq_q.size(), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule